// File: doc/BRIEF.md
# UART Receiver with Receive FIFO and Split Interrupts

This block is the receive half of an asynchronous serial port. It watches a single serial line that idles high. It locks onto a start bit and collects a character of 7 or 8 data bits, least significant bit first. An optional even or odd parity bit follows, then one or two stop bits. Each completed character passes a fixed set of checks before it is written, with its parity and framing error tags, into a 16-entry receive FIFO. The host reads the FIFO in show-ahead form.

Bit timing comes from a sample-enable strobe that runs at sixteen times the bit rate. A two-flop synchroniser guards the line. The frame sequencer has six states:

- IDLE waits for a low sample. From there it goes IDLE→START.
- START counts to the half-bit point. START→IDLE abandons a glitch. START→DATA confirms the start bit.
- DATA collects the data bits. DATA→PARITY is taken when parity is enabled, otherwise DATA→STOP1.
- PARITY samples the parity bit and then moves PARITY→STOP1.
- STOP1 samples the first stop bit. STOP1→IDLE ends a one-stop frame. STOP1→STOP2 is taken when two stop bits are set.
- STOP2 waits out the second stop bit without checking it, then moves STOP2→IDLE.

Five sticky status flags record conditions: trigger reached, data ready by timeout, character error, break and overrun. The host clears them with a strobe and a mask. Three interrupt outputs combine these flags with two enable inputs.

Top module: `uart_rx_fifo`

## Requirements
- R1: A low level on the idle line starts a frame only if the line is still low at the middle of the start bit, 8 sample strobes later. A low pulse shorter than that stores nothing and sets no flag.
- R2: Data bits are taken least significant bit first. With `cfg_len7`=1, seven bits are received and `rd_data[7]` reads 0.
- R3: When `cfg_par_en`=1, the bit after the data is parity. With `cfg_par_odd`=0 the data and parity bits together hold an even number of ones; with `cfg_par_odd`=1, an odd number. A mismatch still stores the character, with `rd_perr`=1, and sets `st_err`.
- R4: A 0 in the first stop bit stores the character with `rd_ferr`=1 and sets `st_err`. With `cfg_stop2`=1 the second stop bit is never checked.
- R5: A frame that completes while the FIFO holds 16 characters is discarded and sets `st_ovr`. While `st_ovr` is 1, no character is stored.
- R6: A frame whose data, parity and first stop bit are all 0 is a break. It sets `st_brk` and is not stored. While `st_brk` is 1, no character is stored.
- R7: `st_full` sets whenever `fifo_count` is at or above the trigger level. `cfg_trig` codes 0, 1, 2 and 3 select levels 1, 4, 8 and 14.
- R8: `st_ready` sets when the FIFO is non-empty, holds fewer characters than the trigger level, and sees no frame activity and no read for 15 bit times (240 sample strobes).
- R9: All five flags reset to 0 and stay at 1 until a cycle with `clr_en`=1 and the matching `clr_mask` bit set. The mask bits are: bit 0 `st_full`, bit 1 `st_ready`, bit 2 `st_err`, bit 3 `st_brk`, bit 4 `st_ovr`. A setting condition in the same cycle wins, so `st_full` cannot be cleared while the count is at or above the trigger level.
- R10: `irq_rxf` = `cfg_rie` AND (`st_full` OR `st_ready`). `irq_err` = (`cfg_rie` OR `cfg_reie`) AND `st_err`. `irq_brk` = (`cfg_rie` OR `cfg_reie`) AND (`st_brk` OR `st_ovr`).
- R11: The FIFO returns characters in arrival order. `rd_data`, `rd_perr` and `rd_ferr` show the oldest entry, and `rd_en` removes it at the clock edge.
- R12: While `cfg_rx_en`=0 the line is ignored: the frame sequencer stays in IDLE and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Sample strobe at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_len7 | input | 1 | 1 = 7 data bits, 0 = 8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_trig | input | 2 | Trigger level code (1/4/8/14) |
| cfg_rie | input | 1 | Receive interrupt enable |
| cfg_reie | input | 1 | Error interrupt enable |
| rd_en | input | 1 | Pop the oldest FIFO entry |
| rd_data | output | 8 | Oldest character |
| rd_perr | output | 1 | Parity error tag of oldest character |
| rd_ferr | output | 1 | Framing error tag of oldest character |
| fifo_count | output | 5 | Characters held |
| clr_en | input | 1 | Flag clear strobe |
| clr_mask | input | 5 | Flags to clear |
| st_full | output | 1 | Trigger level reached |
| st_ready | output | 1 | Data ready by timeout |
| st_err | output | 1 | Parity or framing error stored |
| st_brk | output | 1 | Break received |
| st_ovr | output | 1 | Overrun |
| irq_rxf | output | 1 | Receive-full interrupt |
| irq_err | output | 1 | Receive-error interrupt |
| irq_brk | output | 1 | Break/overrun interrupt |

## Verification
A wrong sequencer state or bit counter shows up within one frame. The character read out then has shifted or swapped bits, or carries the wrong tag. It may also never arrive, or a glitch may be stored as a character. A gating fault between the sequencer and the FIFO appears at the first frame after a break or overrun, as a `fifo_count` that still rises. A flag or timeout counter that is off shows within one bit time of its setting event, on the `st_*` outputs and the interrupt lines.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PARITY, S_STOP1, S_STOP2
    } rx_state_e;

    typedef struct packed {
        logic       perr;
        logic       ferr;
        logic [7:0] data;
    } rx_char_t;

    localparam int FL_FULL  = 0;
    localparam int FL_READY = 1;
    localparam int FL_ERR   = 2;
    localparam int FL_BRK   = 3;
    localparam int FL_OVR   = 4;
    localparam int NFLAGS   = 5;

    function automatic logic [4:0] trig_level(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd14;
        endcase
    endfunction
endpackage

// File: rtl/rxf_frame.sv
module rxf_frame
    import rxf_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     rxd_s,
    input  logic     enable,
    input  logic     len7,
    input  logic     par_en,
    input  logic     par_odd,
    input  logic     stop2,
    output logic     done,
    output rx_char_t chr,
    output logic     brk,
    output logic     busy
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    rx_state_e state, nxt;
    logic [CW-1:0] cnt;
    logic [2:0]    bidx;
    logic [7:0]    sh;
    logic          pbit, stop_r, zero;
    logic          bit_tick, stop_now;
    logic [2:0]    last_bit;

    assign bit_tick = tick && (cnt == LAST);
    assign last_bit = len7 ? 3'd6 : 3'd7;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (tick && !rxd_s) nxt = S_START;
            S_START:  if (tick && cnt == MID) nxt = rxd_s ? S_IDLE : S_DATA;
            S_DATA:   if (bit_tick && bidx == last_bit) nxt = par_en ? S_PARITY : S_STOP1;
            S_PARITY: if (bit_tick) nxt = S_STOP1;
            S_STOP1:  if (bit_tick) nxt = stop2 ? S_STOP2 : S_IDLE;
            S_STOP2:  if (bit_tick) nxt = S_IDLE;
        endcase
        if (!enable) nxt = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            bidx   <= '0;
            sh     <= '0;
            pbit   <= 1'b0;
            stop_r <= 1'b1;
            zero   <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_IDLE || (state == S_START && nxt == S_DATA))
                cnt <= '0;
            else if (tick)
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (state == S_IDLE) begin
                sh   <= '0;
                bidx <= '0;
                zero <= 1'b1;
            end
            if (state == S_DATA && bit_tick) begin
                sh[bidx] <= rxd_s;
                bidx     <= bidx + 3'd1;
                zero     <= zero & ~rxd_s;
            end
            if (state == S_PARITY && bit_tick) begin
                pbit <= rxd_s;
                zero <= zero & ~rxd_s;
            end
            if (state == S_STOP1 && bit_tick)
                stop_r <= rxd_s;
        end
    end

    always_comb begin
        stop_now = (state == S_STOP1) ? rxd_s : stop_r;
        done     = enable && bit_tick &&
                   ((state == S_STOP1 && !stop2) || state == S_STOP2);
        chr.data = sh;
        chr.ferr = !stop_now;
        chr.perr = par_en && (^sh ^ pbit ^ par_odd);
        brk      = zero && !stop_now;
        busy     = (state != S_IDLE);
    end
endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  rx_char_t                   wdata,
    input  logic                       pop,
    output rx_char_t                   rdata,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    rx_char_t      mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import rxf_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DEPTH  = 16,
    parameter int TO_ETU = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_en,
    input  logic       rxd,
    input  logic       cfg_rx_en,
    input  logic       cfg_len7,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_stop2,
    input  logic [1:0] cfg_trig,
    input  logic       cfg_rie,
    input  logic       cfg_reie,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic [4:0] fifo_count,
    input  logic       clr_en,
    input  logic [4:0] clr_mask,
    output logic       st_full,
    output logic       st_ready,
    output logic       st_err,
    output logic       st_brk,
    output logic       st_ovr,
    output logic       irq_rxf,
    output logic       irq_err,
    output logic       irq_brk
);
    localparam int CNTW     = $clog2(DEPTH + 1);
    localparam int TO_TICKS = TO_ETU * OVS;
    localparam int TW       = $clog2(TO_TICKS + 1);

    logic [1:0]        sync;
    logic              fr_done, fr_brk, fr_busy;
    rx_char_t          fr_chr, head;
    logic [CNTW-1:0]   cnt;
    logic [TW-1:0]     to_cnt;
    logic [NFLAGS-1:0] flags, set_vec;
    logic              full, above, store_ok, pop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    rxf_frame #(.OVS(OVS)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(sample_en), .rxd_s(sync[1]),
        .enable(cfg_rx_en), .len7(cfg_len7), .par_en(cfg_par_en),
        .par_odd(cfg_par_odd), .stop2(cfg_stop2),
        .done(fr_done), .chr(fr_chr), .brk(fr_brk), .busy(fr_busy)
    );

    assign full     = (cnt == CNTW'(DEPTH));
    assign above    = (cnt >= CNTW'(trig_level(cfg_trig)));
    assign pop      = rd_en && (cnt != '0);
    assign store_ok = fr_done && !fr_brk && !flags[FL_BRK] && !flags[FL_OVR] && !full;

    rxf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(store_ok), .wdata(fr_chr),
        .pop(pop), .rdata(head), .count(cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            to_cnt <= '0;
        else if (fr_busy || fr_done || pop || cnt == '0 || above)
            to_cnt <= '0;
        else if (sample_en && to_cnt != TW'(TO_TICKS))
            to_cnt <= to_cnt + 1'b1;
    end

    always_comb begin
        set_vec           = '0;
        set_vec[FL_FULL]  = above;
        set_vec[FL_READY] = sample_en && (to_cnt == TW'(TO_TICKS - 1)) &&
                            !fr_busy && !pop && cnt != '0 && !above;
        set_vec[FL_ERR]   = store_ok && (fr_chr.perr || fr_chr.ferr);
        set_vec[FL_BRK]   = fr_done && fr_brk;
        set_vec[FL_OVR]   = fr_done && !fr_brk && !flags[FL_BRK] && full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~(clr_en ? clr_mask : '0)) | set_vec;
    end

    assign rd_data    = head.data;
    assign rd_perr    = head.perr;
    assign rd_ferr    = head.ferr;
    assign fifo_count = 5'(cnt);
    assign st_full    = flags[FL_FULL];
    assign st_ready   = flags[FL_READY];
    assign st_err     = flags[FL_ERR];
    assign st_brk     = flags[FL_BRK];
    assign st_ovr     = flags[FL_OVR];
    assign irq_rxf    = cfg_rie && (st_full || st_ready);
    assign irq_err    = (cfg_rie || cfg_reie) && st_err;
    assign irq_brk    = (cfg_rie || cfg_reie) && (st_brk || st_ovr);
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int DEPTH = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_rx_en,
    input logic [1:0] cfg_trig,
    input logic       cfg_rie,
    input logic       cfg_reie,
    input logic       rd_en,
    input logic [4:0] fifo_count,
    input logic       clr_en,
    input logic [4:0] clr_mask,
    input logic       st_full,
    input logic       st_brk,
    input logic       st_ovr,
    input logic       irq_rxf,
    input logic       irq_err,
    input logic       irq_brk
);
    AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= 5'(DEPTH)); // R5
    AST_OVR_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        st_ovr && !rd_en |=> fifo_count <= $past(fifo_count)); // R5
    AST_BRK_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        st_brk && !rd_en |=> fifo_count <= $past(fifo_count)); // R6
    AST_FULL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count >= rxf_pkg::trig_level(cfg_trig) |=> st_full); // R7
    AST_BRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_brk && !(clr_en && clr_mask[3]) |=> st_brk); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rie && !cfg_reie |-> !irq_rxf && !irq_err && !irq_brk); // R10
    AST_RXOFF_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rx_en && !rd_en |=> fifo_count <= $past(fifo_count)); // R12
endmodule

bind uart_rx_fifo rxf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_rx_en(cfg_rx_en), .cfg_trig(cfg_trig),
    .cfg_rie(cfg_rie), .cfg_reie(cfg_reie), .rd_en(rd_en),
    .fifo_count(fifo_count), .clr_en(clr_en), .clr_mask(clr_mask),
    .st_full(st_full), .st_brk(st_brk), .st_ovr(st_ovr),
    .irq_rxf(irq_rxf), .irq_err(irq_err), .irq_brk(irq_brk)
);

// File: tb/tb_uart_rx_fifo.sv
module tb_uart_rx_fifo;
    logic clk = 1'b0, rst_n = 1'b0, sample_en = 1'b0, rxd = 1'b1;
    logic cfg_rx_en = 1'b1, cfg_len7 = 1'b0, cfg_par_en = 1'b1, cfg_par_odd = 1'b0;
    logic cfg_stop2 = 1'b0, cfg_rie = 1'b1, cfg_reie = 1'b0, rd_en = 1'b0, clr_en = 1'b0;
    logic [1:0] cfg_trig = 2'd0;
    logic [4:0] clr_mask = '0;
    logic [7:0] rd_data;
    logic rd_perr, rd_ferr, st_full, st_ready, st_err, st_brk, st_ovr;
    logic irq_rxf, irq_err, irq_brk;
    logic [4:0] fifo_count;

    int checks = 0, fails = 0;
    logic [9:0] expq[$];

    always #10 clk = ~clk;
    always @(posedge clk) sample_en <= ~sample_en;

    uart_rx_fifo dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bits(input logic b, input int n);
        rxd = b;
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic bad_par, input logic s1,
                        input logic s2, input logic store);
        logic [7:0] m;
        logic p;
        m = cfg_len7 ? {1'b0, d[6:0]} : d;
        p = (^m) ^ cfg_par_odd ^ bad_par;
        bits(1'b0, 16);
        for (int i = 0; i < (cfg_len7 ? 7 : 8); i++) bits(m[i], 16);
        if (cfg_par_en) bits(p, 16);
        bits(s1, 16);
        if (cfg_stop2) begin
            if (s2) bits(1'b1, 16);
            else begin bits(1'b0, 10); bits(1'b1, 6); end
        end
        bits(1'b1, 4);
        if (store) expq.push_back({bad_par & cfg_par_en, ~s1, m});
    endtask

    task automatic drain(input string req);
        while (fifo_count != 0) begin
            if (expq.size() == 0) chk(req, {rd_perr, rd_ferr, rd_data}, 10'h3FF);
            else chk(req, {22'd0, rd_perr, rd_ferr, rd_data}, {22'd0, expq.pop_front()});
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk({req, " queue empty"}, expq.size(), 0);
    endtask

    task automatic clear(input logic [4:0] m);
        clr_mask = m; clr_en = 1'b1;
        @(negedge clk);
        clr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset flags", {st_full, st_ready, st_err, st_brk, st_ovr}, 0);
        chk("R9 reset count", fifo_count, 0);
        chk("R10 reset irqs", {irq_rxf, irq_err, irq_brk}, 0);

        // R2 R11: good 8-bit even-parity frame
        send(8'hA5, 0, 1, 1, 1);
        chk("R7 full at level 1", st_full, 1);
        chk("R10 irq_rxf", irq_rxf, 1);
        drain("R2 R11 data");
        clear(5'b00001);
        chk("R9 full cleared", st_full, 0);

        // R1: glitch shorter than half a bit
        bits(1'b0, 4); bits(1'b1, 30);
        chk("R1 glitch count", fifo_count, 0);
        chk("R1 glitch flags", {st_full, st_err, st_brk}, 0);

        // R3: parity error, even then odd
        send(8'h3C, 1, 1, 1, 1);
        chk("R3 err flag", st_err, 1);
        chk("R10 irq_err", irq_err, 1);
        cfg_par_odd = 1'b1;
        send(8'h3C, 0, 1, 1, 1);
        send(8'h01, 1, 1, 1, 1);
        drain("R3 parity tags");
        cfg_par_odd = 1'b0;
        clear(5'b00101);
        chk("R9 err cleared", st_err, 0);

        // R4: bad first stop, then unchecked second stop
        send(8'h5A, 0, 0, 1, 1);
        chk("R4 err flag", st_err, 1);
        cfg_stop2 = 1'b1;
        send(8'hC3, 0, 1, 0, 1);
        drain("R4 stop tags");
        cfg_stop2 = 1'b0;
        clear(5'b00101);

        // R2: 7-bit, no parity
        cfg_len7 = 1'b1; cfg_par_en = 1'b0;
        send(8'hD5, 0, 1, 1, 1);
        send(8'h81, 0, 1, 1, 1);
        drain("R2 seven bit");
        cfg_len7 = 1'b0; cfg_par_en = 1'b1;
        clear(5'b00001);

        // R6: break
        send(8'h00, 0, 0, 1, 0);
        chk("R6 brk flag", st_brk, 1);
        chk("R10 irq_brk", irq_brk, 1);
        chk("R6 break not stored", fifo_count, 0);
        send(8'h77, 0, 1, 1, 0);
        chk("R6 gated while brk", fifo_count, 0);
        clear(5'b01000);
        chk("R9 brk cleared", st_brk, 0);
        send(8'h77, 0, 1, 1, 1);
        drain("R6 after clear");
        clear(5'b00001);

        // R5 R7: overrun at trigger 14
        cfg_trig = 2'd3;
        for (int i = 0; i < 13; i++) send(8'(i * 7 + 3), 0, 1, 1, 1);
        chk("R7 below 14", st_full, 0);
        send(8'hE1, 0, 1, 1, 1);
        chk("R7 at 14", st_full, 1);
        send(8'hE2, 0, 1, 1, 1);
        send(8'hE3, 0, 1, 1, 1);
        chk("R5 no ovr at 16", st_ovr, 0);
        send(8'hE4, 0, 1, 1, 0);
        chk("R5 ovr flag", st_ovr, 1);
        chk("R5 count 16", fifo_count, 16);
        drain("R5 R11 order");
        send(8'h42, 0, 1, 1, 0);
        chk("R5 gated while ovr", fifo_count, 0);
        clear(5'b10001);
        send(8'h42, 0, 1, 1, 1);
        drain("R5 after clear");
        clear(5'b11111);

        // R8: data-ready timeout
        send(8'h99, 0, 1, 1, 1);
        repeat (200) @(negedge clk);
        chk("R8 not yet", st_ready, 0);
        repeat (400) @(negedge clk);
        chk("R8 ready", st_ready, 1);
        chk("R10 irq_rxf ready", irq_rxf, 1);
        drain("R8 data");
        clear(5'b11111);

        // R10: only error enable set
        cfg_trig = 2'd0; cfg_rie = 1'b0; cfg_reie = 1'b1;
        send(8'h12, 1, 1, 1, 1);
        chk("R10 rxf masked", irq_rxf, 0);
        chk("R10 err via reie", irq_err, 1);
        drain("R10 data");
        clear(5'b11111);
        cfg_rie = 1'b1;

        // R12: receiver disabled
        cfg_rx_en = 1'b0;
        send(8'h34, 0, 1, 1, 0);
        chk("R12 nothing stored", fifo_count, 0);
        chk("R12 no flags", {st_full, st_err, st_brk, st_ovr}, 0);
        cfg_rx_en = 1'b1;
        send(8'h34, 0, 1, 1, 1);
        drain("R12 re-enabled");

        finish_run();
    end
endmodule